// File: doc/BRIEF.md
# DAC Power-Up Initialization Sequencer

This block sits on the host side of a serial link to a precision voltage-output DAC. At power-on the DAC's output is clamped to ground and its output stage is tristated. One start pulse makes the block run a fixed script of six 24-bit frames. It hands each frame to an SPI master and waits until that master reports the transfer finished. When the script ends, the block reports whether the DAC returned the clear code that was written to it.

The script runs in this order:

1. A control write that releases the clamp and tristate, selects offset-binary coding, leaves the amplifier powered down, keeps the serial output enabled and sets linearity compensation to zero.
2. A midscale code write to the DAC register.
3. A full-scale code write to the clear-code register.
4. A software-control write that sets the clear bit.
5. A read request for the clear-code register.
6. A no-operation frame that clocks the reply out.

The reply captured during the last frame is compared with the clear code.

Frames leave through a valid/ready stream port. `tx_valid` rises when a frame is available and stays high, with `tx_data` held, until the master takes it by raising `tx_ready`. The master may hold `tx_ready` low for any number of cycles. The end of each transfer is signalled by a one-cycle `xfer_done` pulse with the received word on `rx_data`.

Top module: `dac_init_seq`

## Requirements
- R1: After reset, `tx_valid`, `busy`, `done`, `pass` and `fail` are all low.
- R2: Frame layout: bit 23 is the read flag, bits 22:20 are the register address and bits 19:0 are the data field. Address codes are 000 no-op, 001 DAC code, 010 control, 011 clear code and 100 software control. A `start` pulse while idle or finished raises `busy`, and the first frame offered is the control write 0x200012.
- R3: With DATA_BITS=20 the frames are offered in the order 0x200012, 0x180000, 0x3FFFFF, 0x400002, 0xB00000, 0x000000. Each data code is left-aligned in the 20-bit field, so with DATA_BITS=18 the clear code frame is 0x3FFFFC.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged. A frame is handed over in the cycle where both are high, and `tx_valid` is low in the next cycle.
- R5: After a frame is handed over, no new frame is offered until `xfer_done` pulses. An `xfer_done` pulse while a frame is still waiting to be handed over has no effect.
- R6: On `xfer_done` for the final no-op frame, the upper DATA_BITS bits of `rx_data[19:0]` are compared with the clear code. Bits 23:20 and any bits below the code are ignored. On a match, `pass` and `done` go high and `busy` goes low.
- R7: On a mismatch, `fail` and `done` go high, `pass` stays low and no further frame is offered.
- R8: A `start` pulse while `busy` is high has no effect on the frame order or contents.
- R9: A `start` pulse while `done` is high clears `pass`, `fail` and `done` and runs the whole script again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the script |
| tx_data | output | 24 | Frame offered to the SPI master |
| tx_valid | output | 1 | Frame on `tx_data` is valid |
| tx_ready | input | 1 | SPI master accepts the frame |
| xfer_done | input | 1 | One-cycle pulse: the current transfer has completed |
| rx_data | input | 24 | Word shifted in during the completed transfer |
| busy | output | 1 | Script in progress |
| done | output | 1 | Script finished, verdict valid |
| pass | output | 1 | Read-back clear code matched |
| fail | output | 1 | Read-back clear code did not match |

## Verification
The bench builds the block with its defaults: DATA_BITS=20 and the control field 0x00012. This makes the exact frame words 0x3FFFFF and 0xB00000 observable and puts all 20 reply bits under comparison, so a single flipped low bit must produce `fail`. The bench runs the script under several handover delay patterns. It also injects stray `start` and `xfer_done` pulses, and varies the reply's upper nibble to show that those bits are ignored.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  localparam int FRAME_W  = 24;
  localparam int FIELD_W  = 20;
  localparam int N_FRAMES = 6;
  localparam int IDX_W    = $clog2(N_FRAMES);

  // register address codes (decoded by the DAC)
  localparam logic [2:0] ADR_NOP   = 3'b000;
  localparam logic [2:0] ADR_CODE  = 3'b001;
  localparam logic [2:0] ADR_CFG   = 3'b010;
  localparam logic [2:0] ADR_CLR   = 3'b011;
  localparam logic [2:0] ADR_SWCTL = 3'b100;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OFFER,
    ST_WAIT,
    ST_FINISH
  } seq_state_e;
endpackage

// File: rtl/dac_seq_script.sv
module dac_seq_script
  import dac_seq_pkg::*;
#(
  parameter int               DATA_BITS  = 20,
  parameter logic [FIELD_W-1:0] CFG_FIELD = 20'h00012
) (
  input  logic [IDX_W-1:0]   step,
  output logic [FRAME_W-1:0] frame,
  output logic [FIELD_W-1:0] clr_field,
  output logic [FIELD_W-1:0] cmp_mask
);
  localparam int PAD = FIELD_W - DATA_BITS;
  localparam logic [FIELD_W-1:0] ONES = {FIELD_W{1'b1}};
  localparam logic [FIELD_W-1:0] MASK = ONES << PAD;
  localparam logic [FIELD_W-1:0] MID  = {1'b1, {(FIELD_W-1){1'b0}}};
  localparam logic [FIELD_W-1:0] SW_CLEAR = 20'h00002;

  assign clr_field = MASK;
  assign cmp_mask  = MASK;

  always_comb begin
    case (step)
      3'd0:    frame = {1'b0, ADR_CFG,   CFG_FIELD};
      3'd1:    frame = {1'b0, ADR_CODE,  MID};
      3'd2:    frame = {1'b0, ADR_CLR,   MASK};
      3'd3:    frame = {1'b0, ADR_SWCTL, SW_CLEAR};
      3'd4:    frame = {1'b1, ADR_CLR,   {FIELD_W{1'b0}}};
      default: frame = {1'b0, ADR_NOP,   {FIELD_W{1'b0}}};
    endcase
  end
endmodule

// File: rtl/dac_readback_cmp.sv
module dac_readback_cmp
  import dac_seq_pkg::*;
(
  input  logic [FRAME_W-1:0] rx_word,
  input  logic [FIELD_W-1:0] expect_field,
  input  logic [FIELD_W-1:0] mask,
  output logic               match
);
  logic [FIELD_W-1:0] diff;
  assign diff  = (rx_word[FIELD_W-1:0] ^ expect_field) & mask;
  assign match = (diff == '0);
endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tx_ready,
  input  logic             xfer_done,
  input  logic             match,
  input  logic [FRAME_W-1:0] frame,
  output logic [IDX_W-1:0] step,
  output logic             tx_valid,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             fail
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_FRAMES - 1);

  seq_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
      pass  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_FINISH: begin
          if (start) begin
            state <= ST_OFFER;
            step  <= '0;
            pass  <= 1'b0;
            fail  <= 1'b0;
          end
        end
        ST_OFFER: begin
          if (tx_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (xfer_done) begin
            if (step == LAST) begin
              state <= ST_FINISH;
              pass  <= match;
              fail  <= !match;
            end else begin
              step  <= step + 1'b1;
              state <= ST_OFFER;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_valid = (state == ST_OFFER);
  assign busy     = (state == ST_OFFER) || (state == ST_WAIT);
  assign done     = (state == ST_FINISH);

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(frame)); // R4
  AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_valid); // R4
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail)); // R6
  AST_FINISH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_valid && !busy); // R7
  AST_VERDICT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || fail) |-> done); // R9
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST); // R3
endmodule

// File: rtl/dac_init_seq.sv
module dac_init_seq
  import dac_seq_pkg::*;
#(
  parameter int                 DATA_BITS = 20,
  parameter logic [FIELD_W-1:0] CFG_FIELD = 20'h00012
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic [FRAME_W-1:0] tx_data,
  output logic               tx_valid,
  input  logic               tx_ready,
  input  logic               xfer_done,
  input  logic [FRAME_W-1:0] rx_data,
  output logic               busy,
  output logic               done,
  output logic               pass,
  output logic               fail
);
  logic [IDX_W-1:0]   step;
  logic [FIELD_W-1:0] clr_field;
  logic [FIELD_W-1:0] cmp_mask;
  logic               match;

  dac_seq_script #(.DATA_BITS(DATA_BITS), .CFG_FIELD(CFG_FIELD)) u_script (
    .step      (step),
    .frame     (tx_data),
    .clr_field (clr_field),
    .cmp_mask  (cmp_mask)
  );

  dac_readback_cmp u_cmp (
    .rx_word      (rx_data),
    .expect_field (clr_field),
    .mask         (cmp_mask),
    .match        (match)
  );

  dac_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tx_ready  (tx_ready),
    .xfer_done (xfer_done),
    .match     (match),
    .frame     (tx_data),
    .step      (step),
    .tx_valid  (tx_valid),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .fail      (fail)
  );

  AST_START_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> tx_valid && tx_data == {1'b0, ADR_CFG, CFG_FIELD}); // R2
endmodule

// File: tb/dac_init_seq_tb.sv
module dac_init_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        xfer_done = 1'b0;
  logic [23:0] rx_data = '0;
  logic        busy, done, pass, fail;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dac_init_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .xfer_done(xfer_done), .rx_data(rx_data),
    .busy(busy), .done(done), .pass(pass), .fail(fail)
  );

  // {expected frame, ready delay, done delay}
  localparam logic [39:0] SCRIPT [6] = '{
    {24'h200012, 8'd0, 8'd2},
    {24'h180000, 8'd3, 8'd0},
    {24'h3FFFFF, 8'd1, 8'd5},
    {24'h400002, 8'd4, 8'd1},
    {24'hB00000, 8'd0, 8'd0},
    {24'h000000, 8'd2, 8'd3}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    for (int n = 0; n < 200 && !tx_valid; n++) @(negedge clk);
  endtask

  // one full script run; returns after verdict sampled
  task automatic run_script(input logic [23:0] reply, input bit exp_pass,
                            input bit stray_start, input bit stray_done, input string tag);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", 32'(busy), 1);
    for (int i = 0; i < 6; i++) begin
      logic [23:0] exp_f;
      int rd, dd;
      exp_f = SCRIPT[i][39:16];
      rd = int'(SCRIPT[i][15:8]);
      dd = int'(SCRIPT[i][7:0]);
      wait_valid();
      check(tx_valid === 1'b1 && tx_data === exp_f, "R3 frame order", 32'(tx_data), 32'(exp_f));
      for (int k = 0; k < rd; k++) begin
        if (stray_done && k == 0) xfer_done = 1'b1;
        if (stray_start && k == 0) start = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0; start = 1'b0;
        check(tx_valid === 1'b1 && tx_data === exp_f, "R4/R5/R8 hold while not ready", 32'(tx_data), 32'(exp_f));
      end
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      check(tx_valid === 1'b0, "R4 valid drops after handover", 32'(tx_valid), 0);
      for (int k = 0; k < dd; k++) begin
        @(negedge clk);
        check(tx_valid === 1'b0, "R5 no frame before done", 32'(tx_valid), 0);
      end
      rx_data = (i == 5) ? reply : 24'h0;
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
    end
    check(done === 1'b1 && busy === 1'b0, {tag, " done"}, {30'd0, done, busy}, 32'h2);
    check(pass === exp_pass && fail === !exp_pass, {tag, " verdict"}, {30'd0, pass, fail},
          {30'd0, exp_pass, !exp_pass});
    for (int k = 0; k < 4; k++) @(negedge clk);
    check(tx_valid === 1'b0 && done === 1'b1, "R7 idle after verdict", 32'(tx_valid), 0);
  endtask

  initial begin
    for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tx_valid === 1'b0 && busy === 1'b0 && done === 1'b0 && pass === 1'b0 && fail === 1'b0,
          "R1 reset state", {27'd0, tx_valid, busy, done, pass, fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_valid === 1'b0 && busy === 1'b0, "R1 idle after reset", 32'(tx_valid), 0);

    // R6 exact reply passes
    run_script(24'h3FFFFF, 1'b1, 1'b0, 1'b0, "R6 match");
    // R9 rerun, R8 stray start, R5 stray done; upper nibble ignored (R6)
    run_script(24'hBFFFFF, 1'b1, 1'b1, 1'b1, "R9 rerun R6 upper ignored");
    // R7 single low bit wrong
    run_script(24'h3FFFFE, 1'b0, 1'b0, 1'b0, "R7 bit0 mismatch");
    // R9 pass after fail clears fail
    run_script(24'h0FFFFF, 1'b1, 1'b0, 1'b0, "R9 clear after fail");
    // R7 top bit of field wrong
    run_script(24'h37FFFF, 1'b0, 1'b1, 1'b0, "R7 msb mismatch");

    // R1 reset mid-run
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(tx_valid === 1'b0 && busy === 1'b0 && done === 1'b0 && fail === 1'b0,
          "R1 reset mid-run", {28'd0, tx_valid, busy, done, fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 first frame after restart from idle
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(tx_valid === 1'b1 && tx_data === 24'h200012, "R2 first frame", 32'(tx_data), 32'h200012);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule